// File: doc/BRIEF.md
# UTOPIA Receive Cell Ingress Controller

This block is the ATM-layer end of a byte-wide UTOPIA Level 1 receive link. Using the byte-by-byte handshake, it reads 53-byte cells from an external PHY receive FIFO, one byte per clock. It drives an active-low read enable. It samples an active-low empty flag, the data byte and a start-of-cell marker. Read data is pipelined: a byte shows up on the data bus one clock after the cycle that requested it. Every request decision therefore has to count that byte still in flight.

Accepted bytes go into an internal store that holds a whole number of cells. The reader sees a cell only once all 53 bytes of it have arrived. Bytes leave the store with first-byte and last-byte tags under a valid/ready handshake.

Flow control works on whole cells. A new cell is requested only when the store has room for the entire cell. In the final cell before the store fills, a throttling rule protects the last three bytes: while the PHY reports empty, the enable alternates on and off instead of staying asserted. A start-of-cell that arrives early throws away the partial cell and raises an error pulse. Bytes that arrive with no cell in progress are dropped.

Top module: `utopia_rx_ingress`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rx_enb_n` is 1. While `rst` is high, `out_valid` and `runt_err` are 0.
- R2: A byte on `rx_data`/`rx_soc` is taken at a rising edge only if, in the previous cycle, `rx_enb_n` was 0 and `rx_empty_n` was 1. Values presented at any other time have no effect on the output stream.
- R3: Stored cells leave in arrival order, one byte per edge where `out_valid` and `out_ready` are both 1. `out_sop` is 1 on the first byte of a cell and `out_eop` is 1 on the 53rd byte. While `out_valid` is 1 and `out_ready` is 0, the presented byte and its tags hold.
- R4: Read enable is asserted to start a cell only when the free byte space is at least 53 plus any byte still in flight. With the reader stalled and CELLS cells stored, `rx_enb_n` stays 1 and no further byte is fetched.
- R5: The store never receives a byte while it is full, and every byte of every complete cell is delivered intact after the store has filled.
- R6: During the cell whose completion leaves no room for another cell, the enable alternates whenever `rx_empty_n` is 0 while bytes 51 to 53 are being requested. `rx_enb_n` is never 0 in two consecutive cycles under that condition.
- R7: When the store can hold another cell after the current one, `rx_enb_n` stays 0 while `rx_empty_n` is 0 in the middle of a cell.
- R8: A start-of-cell byte accepted after 1 to 52 bytes of a cell removes that partial cell from the store. It raises `runt_err` for exactly one cycle and becomes byte 1 of a new cell.
- R9: A byte accepted without start-of-cell is dropped when no cell is in progress: after reset, after byte 53, or after a dropped byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte from the PHY, valid one cycle after a granted request |
| rx_soc | input | 1 | Marks the first byte of a cell, timed with `rx_data` |
| rx_empty_n | input | 1 | Low when the PHY has no byte to give in this cycle |
| rx_enb_n | output | 1 | Active-low read request to the PHY |
| out_data | output | 8 | Stored byte at the head of the store |
| out_valid | output | 1 | A byte of a complete cell is presented |
| out_sop | output | 1 | Presented byte is byte 1 of its cell |
| out_eop | output | 1 | Presented byte is byte 53 of its cell |
| out_ready | input | 1 | Consumer takes the presented byte at the next edge |
| runt_err | output | 1 | One-cycle pulse when a partial cell is discarded |

## Verification
If the byte counter falls out of step with the cell, the first effect at the ports is a wrong `out_sop`/`out_eop` tag or a missing cell on the output. That shows within one cell time of the fault. A wrong free-space figure shows at `rx_enb_n` in the cycle after the decision: either a request made while the store cannot take the bytes, seen as a fetched byte with the reader stalled, or a stall that never lifts. A rollback pointer left in the wrong place corrupts the next cell the reader sees, byte for byte. An error in the throttle shows as `rx_enb_n` held low for two cycles during an empty stretch in the last cell.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int DATA_W        = 8;
    localparam int CELL_BYTES    = 53;
    localparam int THROTTLE_SPAN = 3;
    localparam int CNT_W         = $clog2(CELL_BYTES + 1);

    typedef logic [CNT_W-1:0]  byte_idx_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_idx_t IDX_FULL = byte_idx_t'(CELL_BYTES);
    localparam byte_idx_t IDX_LAST = byte_idx_t'(CELL_BYTES - 1);

    // one byte as seen at the PHY side, after the one-cycle pipeline
    typedef struct packed {
        logic  valid;
        logic  soc;
        byte_t data;
    } rx_byte_t;

    // command from the cell tracker to the store
    typedef struct packed {
        logic  wr;
        logic  commit;
        logic  rollback;
        byte_t data;
    } store_cmd_t;

    // how the enable decision treats the next cycle
    typedef enum logic [1:0] {
        ZONE_GAP  = 2'd0,
        ZONE_OPEN = 2'd1,
        ZONE_LAST = 2'd2
    } fill_zone_e;

    // true when the next request would fetch one of the final bytes of a cell
    function automatic logic in_tail_window(input byte_idx_t got);
        return (int'(got) >= CELL_BYTES - THROTTLE_SPAN) && (int'(got) < CELL_BYTES);
    endfunction

endpackage

// File: rtl/urx_capture.sv
module urx_capture
    import urx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_enb_n,
    input  logic     rx_empty_n,
    input  byte_t    rx_data,
    input  logic     rx_soc,
    output rx_byte_t byte_o,
    output logic     inflight_o
);

    logic req_q;

    // a request is granted in the cycle where enable is low and empty is high
    assign inflight_o = ~rx_enb_n & rx_empty_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= inflight_o;
        end
    end

    always_comb begin
        byte_o.valid = req_q;
        byte_o.soc   = rx_soc;
        byte_o.data  = rx_data;
    end

endmodule

// File: rtl/urx_cell_tracker.sv
module urx_cell_tracker
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_byte_t   byte_i,
    output store_cmd_t cmd_o,
    output byte_idx_t  got_next_o,
    output logic       runt_err
);

    byte_idx_t got_q;
    logic      runt_d;

    always_comb begin
        got_next_o    = got_q;
        cmd_o         = '0;
        cmd_o.data    = byte_i.data;
        runt_d        = 1'b0;
        if (byte_i.valid) begin
            if (byte_i.soc) begin
                cmd_o.wr   = 1'b1;
                got_next_o = byte_idx_t'(1);
                if (got_q != '0 && got_q != IDX_FULL) begin
                    cmd_o.rollback = 1'b1;
                    runt_d         = 1'b1;
                end
            end else if (got_q == '0 || got_q == IDX_FULL) begin
                got_next_o = '0;
            end else begin
                cmd_o.wr   = 1'b1;
                got_next_o = got_q + 1'b1;
                if (got_q == IDX_LAST) begin
                    cmd_o.commit = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            got_q    <= '0;
            runt_err <= 1'b0;
        end else begin
            got_q    <= got_next_o;
            runt_err <= runt_d;
        end
    end

    // R8: an error pulse follows an accepted start-of-cell byte
    assert_runt_cause_R8: assert property (@(posedge clk) disable iff (rst)
        runt_err |-> $past(byte_i.valid && byte_i.soc))
        else $error("runt pulse without a start-of-cell byte");

endmodule

// File: rtl/urx_cell_store.sv
module urx_cell_store
    import urx_pkg::*;
#(
    parameter  int DEPTH = 212,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  store_cmd_t       cmd_i,
    input  logic             out_ready,
    output byte_t            out_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic [OCC_W-1:0] free_next_o
);

    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] spec_wp_q, commit_wp_q, rd_q;
    logic [PTR_W-1:0] spec_wp_n, commit_wp_n, wr_ptr;
    logic [OCC_W-1:0] used_q, cused_q, used_n, cused_n;
    byte_idx_t        rd_idx_q;
    logic             pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop       = out_ready && (cused_q != '0);
    assign out_valid = (cused_q != '0);
    assign out_data  = mem[rd_q];
    assign out_sop   = (rd_idx_q == '0);
    assign out_eop   = (rd_idx_q == IDX_LAST);

    always_comb begin
        wr_ptr      = cmd_i.rollback ? commit_wp_q : spec_wp_q;
        spec_wp_n   = cmd_i.wr ? step(wr_ptr) : spec_wp_q;
        commit_wp_n = commit_wp_q;
        cused_n     = cused_q - OCC_W'(pop);
        if (cmd_i.rollback) begin
            used_n = cused_n + OCC_W'(cmd_i.wr);
        end else begin
            used_n = used_q - OCC_W'(pop) + OCC_W'(cmd_i.wr);
        end
        if (cmd_i.commit) begin
            commit_wp_n = spec_wp_n;
            cused_n     = used_n;
        end
        free_next_o = OCC_W'(DEPTH) - used_n;
    end

    always_ff @(posedge clk) begin
        if (cmd_i.wr) begin
            mem[wr_ptr] <= cmd_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_wp_q   <= '0;
            commit_wp_q <= '0;
            rd_q        <= '0;
            used_q      <= '0;
            cused_q     <= '0;
            rd_idx_q    <= '0;
        end else begin
            spec_wp_q   <= spec_wp_n;
            commit_wp_q <= commit_wp_n;
            used_q      <= used_n;
            cused_q     <= cused_n;
            if (pop) begin
                rd_q     <= step(rd_q);
                rd_idx_q <= (rd_idx_q == IDX_LAST) ? '0 : rd_idx_q + 1'b1;
            end
        end
    end

    // R5: no byte is written into a full store
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wr && !cmd_i.rollback) |-> (used_q < OCC_W'(DEPTH)))
        else $error("write into a full store");

    // R3: presented byte holds while the consumer stalls
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)))
        else $error("output changed while stalled");

    // R3: a cell's last byte is followed by a cell's first byte
    assert_cell_align_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eop) |=> (!out_valid || out_sop))
        else $error("cell boundary lost at output");

endmodule

// File: rtl/urx_enable_ctrl.sv
module urx_enable_ctrl
    import urx_pkg::*;
#(
    parameter  int DEPTH = 212,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_idx_t        got_next,
    input  logic             inflight_next,
    input  logic [OCC_W-1:0] free_next,
    input  logic             rx_empty_n,
    output logic             rx_enb_n
);

    fill_zone_e zone;
    int         free_i, got_i, infl_i;
    logic       back_off, grant;

    always_comb begin
        free_i = int'(free_next);
        got_i  = int'(got_next);
        infl_i = inflight_next ? 1 : 0;

        if (got_i == 0 || got_i == CELL_BYTES) begin
            zone = ZONE_GAP;
        end else if (free_i + got_i < 2 * CELL_BYTES) begin
            zone = ZONE_LAST;
        end else begin
            zone = ZONE_OPEN;
        end

        // alternate the request while the PHY is dry near the end of the last cell
        back_off = (zone == ZONE_LAST) && in_tail_window(got_next) && !rx_enb_n && !rx_empty_n;

        unique case (zone)
            ZONE_GAP:  grant = (free_i >= CELL_BYTES + infl_i);
            ZONE_LAST: grant = (got_i + infl_i < CELL_BYTES) && !back_off;
            default:   grant = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_enb_n <= 1'b1;
        end else begin
            rx_enb_n <= ~grant;
        end
    end

    // R1: no request in the first cycle after reset
    assert_enb_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rx_enb_n)
        else $error("enable asserted straight out of reset");

endmodule

// File: rtl/utopia_rx_ingress.sv
module utopia_rx_ingress
    import urx_pkg::*;
#(
    parameter int CELLS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_soc,
    input  logic              rx_empty_n,
    output logic              rx_enb_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    input  logic              out_ready,
    output logic              runt_err
);

    localparam int DEPTH = CELLS * CELL_BYTES;
    localparam int OCC_W = $clog2(DEPTH + 1);

    rx_byte_t         cap_byte;
    logic             inflight;
    store_cmd_t       cmd;
    byte_idx_t        got_next;
    logic [OCC_W-1:0] free_next;

    urx_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .rx_enb_n   (rx_enb_n),
        .rx_empty_n (rx_empty_n),
        .rx_data    (rx_data),
        .rx_soc     (rx_soc),
        .byte_o     (cap_byte),
        .inflight_o (inflight)
    );

    urx_cell_tracker u_tracker (
        .clk        (clk),
        .rst        (rst),
        .byte_i     (cap_byte),
        .cmd_o      (cmd),
        .got_next_o (got_next),
        .runt_err   (runt_err)
    );

    urx_cell_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .free_next_o (free_next)
    );

    urx_enable_ctrl #(.DEPTH(DEPTH)) u_enable (
        .clk           (clk),
        .rst           (rst),
        .got_next      (got_next),
        .inflight_next (inflight),
        .free_next     (free_next),
        .rx_empty_n    (rx_empty_n),
        .rx_enb_n      (rx_enb_n)
    );

endmodule

// File: tb/utopia_rx_ingress_tb.sv
module utopia_rx_ingress_tb;
    import urx_pkg::*;

    localparam int CELLS = 4;
    localparam int CB    = CELL_BYTES;

    typedef struct packed {
        logic [1:0] mark;
        logic [7:0] stall;
        logic       soc;
        logic [7:0] data;
    } phy_ent_t;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] rx_data;
    logic       rx_soc;
    logic       rx_empty_n;
    logic       rx_enb_n;
    logic [7:0] out_data;
    logic       out_valid, out_sop, out_eop, out_ready, runt_err;

    always #2 clk = ~clk;

    utopia_rx_ingress #(.CELLS(CELLS)) u_dut (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_soc(rx_soc),
        .rx_empty_n(rx_empty_n), .rx_enb_n(rx_enb_n), .out_data(out_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_ready(out_ready), .runt_err(runt_err)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    phy_ent_t    phy_q[$];
    logic [9:0]  exp_q[$];
    bit          rnd_stall_en = 0, rnd_ready_en = 0, hold_ready_low = 0;
    int          runt_seen = 0, enb_hi_run = 0;
    int          stall_lo[4], stall_pairs[4];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [9:0] exp_word(input int idx, input logic [7:0] d);
        return {idx == 0, idx == CB - 1, d};
    endfunction

    task automatic push_cell(input bit good, input int len, input logic [1:0] mark,
                             input int stall_at, input int stall_n);
        for (int i = 0; i < len; i++) begin
            phy_ent_t e;
            e.data  = 8'($urandom);
            e.soc   = (i == 0);
            e.stall = (i == stall_at) ? 8'(stall_n) : 8'd0;
            e.mark  = (i == stall_at) ? mark : 2'd0;
            phy_q.push_back(e);
            if (good) exp_q.push_back(exp_word(i, e.data));
        end
    endtask

    task automatic push_garbage(input int n);
        for (int i = 0; i < n; i++) begin
            phy_ent_t e;
            e.data = 8'($urandom); e.soc = 1'b0; e.stall = 8'd0; e.mark = 2'd0;
            phy_q.push_back(e);
        end
    endtask

    // PHY model and consumer, all driven at the falling edge
    initial begin
        phy_ent_t cur;
        bit xfer_pend = 0, head_loaded = 0, prev_lo = 0, lo;
        int stall_left = 0;
        logic [1:0] head_mark = 0;
        logic [9:0] want;
        cur = '0;
        rx_data = 8'h00; rx_soc = 1'b0; rx_empty_n = 1'b0; out_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (xfer_pend) begin
                rx_data = cur.data; rx_soc = cur.soc;
            end else begin
                rx_data = 8'($urandom); rx_soc = ($urandom % 4 == 0);
            end
            if (phy_q.size() > 0 && !head_loaded) begin
                stall_left = int'(phy_q[0].stall); head_mark = phy_q[0].mark;
                head_loaded = 1; prev_lo = 0;
            end
            if (phy_q.size() == 0) begin
                rx_empty_n = 1'b0;
            end else if (stall_left > 0) begin
                rx_empty_n = 1'b0;
                stall_left--;
                lo = (rx_enb_n == 1'b0);
                if (lo) stall_lo[head_mark]++;
                if (lo && prev_lo) stall_pairs[head_mark]++;
                prev_lo = lo;
            end else begin
                rx_empty_n = !(rnd_stall_en && ($urandom % 5 == 0));
            end
            xfer_pend = !rx_enb_n && rx_empty_n;
            if (xfer_pend) begin
                cur = phy_q.pop_front();
                head_loaded = 0;
            end
            out_ready = hold_ready_low ? 1'b0 : (rnd_ready_en ? ($urandom % 3 != 0) : 1'b1);
            if (rx_enb_n) enb_hi_run++; else enb_hi_run = 0;
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R3 R9 unexpected output byte", int'(out_data), 0);
                end else begin
                    want = exp_q.pop_front();
                    check({out_sop, out_eop, out_data} == want, "R2 R3 byte/tags",
                          int'({out_sop, out_eop, out_data}), int'(want));
                end
            end
            if (runt_err) runt_seen++;
        end
    end

    task automatic wait_drain(input string req);
        int t = 0;
        while ((phy_q.size() != 0 || exp_q.size() != 0) && t < 20000) begin
            @(negedge clk); t++;
        end
        repeat (8) @(negedge clk);
        check(t < 20000, req, t, 0);
    endtask

    initial begin
        int t;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check(rx_enb_n == 1'b1, "R1 enable idle in reset", int'(rx_enb_n), 1);
        check(out_valid == 1'b0, "R1 no output in reset", int'(out_valid), 0);
        check(runt_err == 1'b0, "R1 no error in reset", int'(runt_err), 0);
        @(negedge clk);
        rst = 1'b0;

        // random traffic, leading and trailing bytes without start-of-cell
        rnd_stall_en = 1; rnd_ready_en = 1;
        push_garbage(7);
        for (int c = 0; c < 6; c++) push_cell(1, CB, 2'd0, -1, 0);
        push_garbage(4);
        for (int c = 0; c < 2; c++) push_cell(1, CB, 2'd0, -1, 0);
        wait_drain("R2 R9 random traffic drained");
        check(out_valid == 1'b0, "R9 no stray cell", int'(out_valid), 0);
        check(runt_seen == 0, "R8 no runt on clean traffic", runt_seen, 0);

        // runt cells of several lengths
        runt_seen = 0;
        push_cell(0, 20, 2'd0, -1, 0); push_cell(1, CB, 2'd0, -1, 0);
        push_cell(0, 52, 2'd0, -1, 0); push_cell(1, CB, 2'd0, -1, 0);
        push_cell(0, 1,  2'd0, -1, 0); push_cell(1, CB, 2'd0, -1, 0);
        wait_drain("R8 runt traffic drained");
        check(runt_seen == 3, "R8 runt pulse count", runt_seen, 3);

        // fill with reader stalled: throttle in last cell, held enable in first
        rnd_stall_en = 0; rnd_ready_en = 0; hold_ready_low = 1;
        for (int k = 0; k < 4; k++) begin stall_lo[k] = 0; stall_pairs[k] = 0; end
        push_cell(1, CB, 2'd1, 50, 8);
        push_cell(1, CB, 2'd0, -1, 0);
        push_cell(1, CB, 2'd0, -1, 0);
        push_cell(1, CB, 2'd2, 50, 8);
        push_cell(1, CB, 2'd0, -1, 0);
        t = 0;
        while (phy_q.size() > CB && t < 2000) begin @(negedge clk); t++; end
        repeat (60) @(negedge clk);
        #1;
        check(phy_q.size() == CB, "R4 R5 no fetch beyond store capacity", phy_q.size(), CB);
        check(enb_hi_run >= 60, "R4 enable held off while full", enb_hi_run, 60);
        check(stall_pairs[1] >= 4, "R7 enable held through empty mid-cell", stall_pairs[1], 4);
        check(stall_pairs[2] == 0, "R6 no back-to-back enable in last-cell tail", stall_pairs[2], 0);
        check(stall_lo[2] >= 2, "R6 enable keeps toggling in last-cell tail", stall_lo[2], 2);
        hold_ready_low = 0;
        wait_drain("R5 all stored cells delivered");
        check(exp_q.size() == 0, "R5 nothing left expected", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule